// File: doc/BRIEF.md
# Shared-Bus SRAM and Flash Select Sequencer

This block sits between a host and a 32-bit memory module in which a static RAM and a flash array hang off the same 19-bit address bus and the same 32-bit data bus. The host presents one request at a time. A request carries a direction, a target memory, a word address, write data and a four-bit lane mask. The block then runs one bus cycle on the module pins. It drives an active-low select for each memory, a shared active-low output enable and, for each memory, four active-low write strobes, one per byte lane. For reads, it returns the captured word with a one-clock done pulse.

All pin timing is built from the system clock. Each minimum time is given as a parameter in picoseconds. The block converts it to a whole number of clocks, rounding upward, so every minimum is met at the configured clock period. The two memories are never selected together. When consecutive requests target different memories, extra dead clocks with every select high are placed between the two cycles. These clocks keep the two devices from fighting over the shared data bus. The flash command protocol is the host's business. This block only moves single words.

Top module: `shared_mem_ctrl`

## Requirements
- R1: After reset, both selects, the output enable and all eight write strobes are high, the data bus is not driven, `reqReady` is 1 and `rspDone` is 0.
- R2: An SRAM read holds `sramCsN` and `oeN` low for SRAM_RD_CYC = ceil(25000 ps / clock period) clocks (7 at 4 ns) with `flashCsN` high and `memAddr` equal to the request address. The word on `memDataIn` in the last of those clocks appears on `rspData` while `rspDone` is high for exactly one clock, the clock after the select is released.
- R3: An SRAM write keeps `oeN` high and drives the request data on `memDataOut` with `memDataOe` = 1 for the whole select window. The window lasts max(ceil(25000 ps / period), WP + 2) clocks, where WP = ceil(20000 ps / period), giving 7 clocks at 4 ns. `sramWeN[i]` is low only when mask bit i is set. It goes low from the second clock of the window for WP clocks (5 at 4 ns). Lane i covers data bits 8i+7..8i.
- R4: `flashCsN` and `sramCsN` are never low in the same clock.
- R5: Whenever any write strobe is low, `oeN` is high and the strobe's own memory select is low.
- R6: When a request targets the other memory than the previous completed access, SWITCH_GAP_CYC clocks (default 1) with all selects high follow acceptance before the new select falls. The first access after reset, and an access to the same memory, start selecting in the clock right after acceptance. Neither select is ever low in the clock after the other one was low.
- R7: A flash read holds `flashCsN` and `oeN` low for ceil(70000 ps / period) clocks (18 at 4 ns), then returns the last sampled word as in R2.
- R8: A flash write lasts max(ceil(70000 ps / period), WPF + 2) clocks (18 at 4 ns), where WPF = ceil(45000 ps / period) (12 at 4 ns). It pulls `flashWeN[i]` low only for set mask bits, from the second clock for WPF clocks, and never touches `sramWeN`.
- R9: A write with an all-zero mask still runs a full select window and pulses `rspDone`, but asserts no write strobe.
- R10: While a cycle is in progress, `reqReady` is 0 and a request held on the inputs is not accepted. It causes no select or strobe activity, either during the cycle or after it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle; a valid request is taken on this clock edge |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqFlash | input | 1 | 1 = flash target, 0 = SRAM target |
| reqAddr | input | 19 | Word address |
| reqWdata | input | 32 | Write data |
| reqMask | input | 4 | Byte-lane enables for writes |
| rspDone | output | 1 | One-clock completion pulse |
| rspData | output | 32 | Captured read word |
| memAddr | output | 19 | Module address bus |
| memDataOut | output | 32 | Data driven to the module |
| memDataOe | output | 1 | 1 = block drives the data bus |
| memDataIn | input | 32 | Data returned by the module |
| sramCsN | output | 1 | SRAM select, active low |
| flashCsN | output | 1 | Flash select, active low |
| oeN | output | 1 | Shared output enable, active low |
| sramWeN | output | 4 | SRAM per-lane write strobes, active low |
| flashWeN | output | 4 | Flash per-lane write strobes, active low |

## Verification
Completion of one access and acceptance of the next fall in the same clock: `rspDone` is high in the idle clock where `reqReady` is also high. The bench therefore presents each following request in the very clock it sees the done pulse. It then judges whether the dead-clock count before the new select matches the target-switch rule, and whether the returned read word is still correct. Back-to-back requests to the same memory and to alternating memories are both run this way. This shows that a switch gap is inserted only when the target changes.

// File: rtl/shared_mem_pkg.sv
package shared_mem_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GAP    = 2'd1,
    ST_ACCESS = 2'd2
  } ctrlState_t;

  // strobes handed from the sequencer to the pin datapath
  typedef struct packed {
    logic load;      // latch the incoming request
    logic selSram;   // SRAM select window
    logic selFlash;  // flash select window
    logic oeEn;      // output enable (reads only)
    logic weEn;      // write pulse window
    logic driveEn;   // drive the shared data bus
    logic capture;   // sample read data
  } memStrobes_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/mem_ctrl_fsm.sv
module mem_ctrl_fsm
  import shared_mem_pkg::*;
#(
  parameter int CLK_PERIOD_PS  = 4000,
  parameter int SRAM_CYCLE_PS  = 25000,
  parameter int SRAM_WP_PS     = 20000,
  parameter int FLASH_CYCLE_PS = 70000,
  parameter int FLASH_WP_PS    = 45000,
  parameter int SWITCH_GAP_CYC = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqFlash,
  output logic        reqReady,
  output memStrobes_t strobes,
  output logic        rspDone
);

  localparam int SRAM_RD_CYC  = ceilDiv(SRAM_CYCLE_PS, CLK_PERIOD_PS);
  localparam int SRAM_WP_CYC  = ceilDiv(SRAM_WP_PS, CLK_PERIOD_PS);
  localparam int SRAM_WR_CYC  = (SRAM_RD_CYC > SRAM_WP_CYC + 2) ? SRAM_RD_CYC : SRAM_WP_CYC + 2;
  localparam int FLASH_RD_CYC = ceilDiv(FLASH_CYCLE_PS, CLK_PERIOD_PS);
  localparam int FLASH_WP_CYC = ceilDiv(FLASH_WP_PS, CLK_PERIOD_PS);
  localparam int FLASH_WR_CYC = (FLASH_RD_CYC > FLASH_WP_CYC + 2) ? FLASH_RD_CYC : FLASH_WP_CYC + 2;
  localparam int MAX_A        = (SRAM_WR_CYC > FLASH_WR_CYC) ? SRAM_WR_CYC : FLASH_WR_CYC;
  localparam int MAX_CYC      = (MAX_A > SWITCH_GAP_CYC) ? MAX_A : SWITCH_GAP_CYC;
  localparam int CNT_W        = $clog2(MAX_CYC + 1);
  localparam int GAP_LAST     = (SWITCH_GAP_CYC > 0) ? SWITCH_GAP_CYC - 1 : 0;

  ctrlState_t       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastCnt;
  logic [CNT_W-1:0] wpEnd;
  logic             curWrite, curFlash;
  logic             lastFlash, haveLast;
  logic             doneQ;
  logic             accEnd;

  always_comb begin
    unique case ({curFlash, curWrite})
      2'b00:   lastCnt = CNT_W'(SRAM_RD_CYC - 1);
      2'b01:   lastCnt = CNT_W'(SRAM_WR_CYC - 1);
      2'b10:   lastCnt = CNT_W'(FLASH_RD_CYC - 1);
      default: lastCnt = CNT_W'(FLASH_WR_CYC - 1);
    endcase
    wpEnd = curFlash ? CNT_W'(FLASH_WP_CYC) : CNT_W'(SRAM_WP_CYC);
  end

  assign accEnd = (state == ST_ACCESS) && (cnt == lastCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      curWrite  <= 1'b0;
      curFlash  <= 1'b0;
      lastFlash <= 1'b0;
      haveLast  <= 1'b0;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= accEnd;
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            curWrite <= reqWrite;
            curFlash <= reqFlash;
            cnt      <= '0;
            if (haveLast && (reqFlash != lastFlash) && (SWITCH_GAP_CYC > 0))
              state <= ST_GAP;
            else
              state <= ST_ACCESS;
          end
        end
        ST_GAP: begin
          if (cnt == CNT_W'(GAP_LAST)) begin
            cnt   <= '0;
            state <= ST_ACCESS;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (accEnd) begin
            state     <= ST_IDLE;
            lastFlash <= curFlash;
            haveLast  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.load     = (state == ST_IDLE) && reqValid;
    strobes.selSram  = (state == ST_ACCESS) && !curFlash;
    strobes.selFlash = (state == ST_ACCESS) && curFlash;
    strobes.oeEn     = (state == ST_ACCESS) && !curWrite;
    strobes.driveEn  = (state == ST_ACCESS) && curWrite;
    strobes.weEn     = (state == ST_ACCESS) && curWrite &&
                       (cnt >= CNT_W'(1)) && (cnt <= wpEnd);
    strobes.capture  = accEnd && !curWrite;
  end

  assign reqReady = (state == ST_IDLE);
  assign rspDone  = doneQ;

endmodule

// File: rtl/mem_ctrl_datapath.sv
module mem_ctrl_datapath
  import shared_mem_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobes_t       strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  input  logic [DATA_W-1:0] memDataIn,
  output logic              sramCsN,
  output logic              flashCsN,
  output logic              oeN,
  output logic [LANES-1:0]  sramWeN,
  output logic [LANES-1:0]  flashWeN
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] rspQ;
  logic [LANES-1:0]  maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      maskQ <= '0;
      rspQ  <= '0;
    end else begin
      if (strobes.load) begin
        addrQ <= reqAddr;
        dataQ <= reqWdata;
        maskQ <= reqMask;
      end
      if (strobes.capture)
        rspQ <= memDataIn;
    end
  end

  genvar lane;
  generate
    for (lane = 0; lane < LANES; lane++) begin : g_lane
      assign sramWeN[lane]  = !(strobes.weEn && strobes.selSram  && maskQ[lane]);
      assign flashWeN[lane] = !(strobes.weEn && strobes.selFlash && maskQ[lane]);
    end
  endgenerate

  assign sramCsN    = !strobes.selSram;
  assign flashCsN   = !strobes.selFlash;
  assign oeN        = !strobes.oeEn;
  assign memDataOe  = strobes.driveEn;
  assign memDataOut = dataQ;
  assign memAddr    = addrQ;
  assign rspData    = rspQ;

endmodule

// File: rtl/shared_mem_ctrl.sv
module shared_mem_ctrl
  import shared_mem_pkg::*;
#(
  parameter int ADDR_W         = 19,
  parameter int DATA_W         = 32,
  parameter int CLK_PERIOD_PS  = 4000,
  parameter int SRAM_CYCLE_PS  = 25000,
  parameter int SRAM_WP_PS     = 20000,
  parameter int FLASH_CYCLE_PS = 70000,
  parameter int FLASH_WP_PS    = 45000,
  parameter int SWITCH_GAP_CYC = 1,
  localparam int LANES         = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic              reqFlash,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  input  logic [DATA_W-1:0] memDataIn,
  output logic              sramCsN,
  output logic              flashCsN,
  output logic              oeN,
  output logic [LANES-1:0]  sramWeN,
  output logic [LANES-1:0]  flashWeN
);

  memStrobes_t strobes;

  mem_ctrl_fsm #(
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .SRAM_CYCLE_PS (SRAM_CYCLE_PS),
    .SRAM_WP_PS    (SRAM_WP_PS),
    .FLASH_CYCLE_PS(FLASH_CYCLE_PS),
    .FLASH_WP_PS   (FLASH_WP_PS),
    .SWITCH_GAP_CYC(SWITCH_GAP_CYC)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqFlash(reqFlash),
    .reqReady(reqReady),
    .strobes (strobes),
    .rspDone (rspDone)
  );

  mem_ctrl_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .reqMask   (reqMask),
    .rspData   (rspData),
    .memAddr   (memAddr),
    .memDataOut(memDataOut),
    .memDataOe (memDataOe),
    .memDataIn (memDataIn),
    .sramCsN   (sramCsN),
    .flashCsN  (flashCsN),
    .oeN       (oeN),
    .sramWeN   (sramWeN),
    .flashWeN  (flashWeN)
  );

endmodule

// File: rtl/shared_mem_ctrl_checker.sv
module shared_mem_ctrl_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqReady,
  input logic             rspDone,
  input logic             memDataOe,
  input logic             oeN,
  input logic             sramCsN,
  input logic             flashCsN,
  input logic [LANES-1:0] sramWeN,
  input logic [LANES-1:0] flashWeN
);

  assert_sel_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(!sramCsN && !flashCsN));

  assert_oe_off_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((sramWeN != '1) || (flashWeN != '1)) |-> oeN);

  assert_sram_we_sel_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sramWeN != '1) |-> !sramCsN);

  assert_flash_we_sel_R5: assert property (@(posedge clk) disable iff (!rstN)
    (flashWeN != '1) |-> !flashCsN);

  assert_flash_to_sram_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    !flashCsN |=> sramCsN);

  assert_sram_to_flash_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    !sramCsN |=> flashCsN);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  assert_drive_no_oe_R3: assert property (@(posedge clk) disable iff (!rstN)
    memDataOe |-> oeN);

  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCsN || !flashCsN) |-> !reqReady);

endmodule

bind shared_mem_ctrl shared_mem_ctrl_checker #(.LANES(LANES)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .rspDone  (rspDone),
  .memDataOe(memDataOe),
  .oeN      (oeN),
  .sramCsN  (sramCsN),
  .flashCsN (flashCsN),
  .sramWeN  (sramWeN),
  .flashWeN (flashWeN)
);

// File: tb/tb_shared_mem_ctrl.sv
`timescale 1ns/1ps
module tb_shared_mem_ctrl;

  // expected counts at a 4 ns clock, from the requirement text
  localparam int SRAM_RD = 7;   // ceil(25/4)
  localparam int SRAM_WR = 7;   // max(7, 5+2)
  localparam int SRAM_WP = 5;   // ceil(20/4)
  localparam int FL_RD   = 18;  // ceil(70/4)
  localparam int FL_WR   = 18;  // max(18, 12+2)
  localparam int FL_WP   = 12;  // ceil(45/4)
  localparam int GAP     = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic        reqFlash = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [3:0]  reqMask = '0;
  logic        rspDone;
  logic [31:0] rspData;
  logic [18:0] memAddr;
  logic [31:0] memDataOut;
  logic        memDataOe;
  logic [31:0] memDataIn;
  logic        sramCsN, flashCsN, oeN;
  logic [3:0]  sramWeN, flashWeN;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  function automatic logic [31:0] pattern(input logic fl, input logic [18:0] a);
    return fl ? {13'h00F0, a} : {13'h01A5, a};
  endfunction

  assign memDataIn = (!oeN && !sramCsN)  ? pattern(1'b0, memAddr) :
                     (!oeN && !flashCsN) ? pattern(1'b1, memAddr) : 32'h0BAD_F00D;

  shared_mem_ctrl dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqFlash(reqFlash), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqMask(reqMask), .rspDone(rspDone),
    .rspData(rspData), .memAddr(memAddr), .memDataOut(memDataOut),
    .memDataOe(memDataOe), .memDataIn(memDataIn), .sramCsN(sramCsN),
    .flashCsN(flashCsN), .oeN(oeN), .sramWeN(sramWeN), .flashWeN(flashWeN)
  );

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
      $finish;
    end
  end

  // Called at a negedge; presents the request at once so it is taken on the
  // next edge, even in the clock where the previous done pulse is visible.
  task automatic runReq(input bit wr, input bit fl, input logic [18:0] a,
                        input logic [31:0] d, input logic [3:0] m,
                        input int expSel, input int expWp, input int expGap,
                        input string req);
    int gapC = 0, selC = 0, firstWe = -1, guard = 0;
    int weC [4] = '{0, 0, 0, 0};
    bit seenSel = 0, oeBad = 0, wrongMem = 0, addrBad = 0, dataBad = 0;
    logic [3:0] weVec, otherWe;
    check(reqReady === 1'b1, req, "ready before request", reqReady, 1);
    reqValid = 1'b1; reqWrite = wr; reqFlash = fl;
    reqAddr = a; reqWdata = d; reqMask = m;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    while (rspDone !== 1'b1 && guard < 100) begin
      guard++;
      if (sramCsN && flashCsN && !seenSel) gapC++;
      if ((fl ? flashCsN : sramCsN) == 1'b0) begin
        seenSel = 1;
        selC++;
        if (memAddr !== a) addrBad = 1;
        if (wr) begin
          if (oeN !== 1'b1) oeBad = 1;
          if (memDataOe !== 1'b1 || memDataOut !== d) dataBad = 1;
        end else if (oeN !== 1'b0) oeBad = 1;
      end
      if ((fl ? sramCsN : flashCsN) == 1'b0) wrongMem = 1;
      weVec   = fl ? ~flashWeN : ~sramWeN;
      otherWe = fl ? ~sramWeN : ~flashWeN;
      if (otherWe != 0) wrongMem = 1;
      for (int l = 0; l < 4; l++)
        if (weVec[l]) begin
          weC[l]++;
          if (firstWe < 0) firstWe = selC - 1;
        end
      @(negedge clk);
    end
    check(rspDone === 1'b1, req, "done pulse seen", rspDone, 1);
    check(sramCsN && flashCsN, req, "selects released at done", {sramCsN, flashCsN}, 2'b11);
    check(gapC == expGap, req, "dead clocks before select", gapC, expGap);
    check(selC == expSel, req, "select window length", selC, expSel);
    check(!wrongMem, req, "other memory untouched", wrongMem, 0);
    check(!addrBad, req, "address held", addrBad, 0);
    check(!oeBad, req, "output enable level", oeBad, 0);
    for (int l = 0; l < 4; l++)
      check(weC[l] == (wr && m[l] ? expWp : 0), req, $sformatf("lane %0d strobe clocks", l),
            weC[l], (wr && m[l]) ? expWp : 0);
    if (wr) begin
      check(!dataBad, req, "write data driven", dataBad, 0);
      if (m != 0) check(firstWe == 1, req, "strobe starts second clock", firstWe, 1);
    end else begin
      check(rspData === pattern(fl, a), req, "read data", rspData, pattern(fl, a));
    end
  endtask

  task automatic testReset();
    check(sramCsN && flashCsN && oeN, "R1", "selects/oe idle", {sramCsN, flashCsN, oeN}, 3'b111);
    check(sramWeN == 4'hF && flashWeN == 4'hF, "R1", "strobes idle", {sramWeN, flashWeN}, 8'hFF);
    check(!memDataOe && reqReady && !rspDone, "R1", "oe/ready/done",
          {memDataOe, reqReady, rspDone}, 3'b010);
  endtask

  // R10: a request held while busy is neither taken nor acted on
  task automatic testBusyIgnore();
    int flashSeen = 0, extraSel = 0, sramWe = 0, guard = 0;
    reqValid = 1'b1; reqWrite = 1'b1; reqFlash = 1'b0;
    reqAddr = 19'h00011; reqWdata = 32'h1122_3344; reqMask = 4'hF;
    @(posedge clk);
    @(negedge clk);
    reqFlash = 1'b1; reqAddr = 19'h00022;  // junk request kept valid
    for (int i = 0; i < 5; i++) begin
      check(reqReady === 1'b0, "R10", "not ready while busy", reqReady, 0);
      if (!flashCsN || flashWeN != 4'hF) flashSeen++;
      if (sramWeN != 4'hF) sramWe++;
      @(negedge clk);
    end
    reqValid = 1'b0;
    while (rspDone !== 1'b1 && guard < 50) begin
      guard++;
      if (!flashCsN || flashWeN != 4'hF) flashSeen++;
      if (sramWeN != 4'hF) sramWe++;
      @(negedge clk);
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!sramCsN || !flashCsN) extraSel++;
    end
    check(flashSeen == 0, "R10", "flash untouched by held request", flashSeen, 0);
    check(extraSel == 0, "R10", "no access after completion", extraSel, 0);
    check(sramWe == SRAM_WP, "R10", "accepted write still ran", sramWe, SRAM_WP);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    runReq(0, 0, 19'h12345, 32'h0, 4'h0, SRAM_RD, 0, 0, "R2");
    runReq(1, 0, 19'h00ABC, 32'hCAFE_F00D, 4'hF, SRAM_WR, SRAM_WP, 0, "R3");
    runReq(1, 0, 19'h00ABD, 32'h5A5A_A5A5, 4'b0101, SRAM_WR, SRAM_WP, 0, "R3");
    runReq(0, 1, 19'h40000, 32'h0, 4'h0, FL_RD, 0, GAP, "R7_R6");
    runReq(1, 1, 19'h00100, 32'h8800_0000, 4'b1000, FL_WR, FL_WP, 0, "R8");
    runReq(1, 1, 19'h00101, 32'hFFFF_FFFF, 4'b0000, FL_WR, 0, 0, "R9");
    runReq(0, 0, 19'h7FFFF, 32'h0, 4'h0, SRAM_RD, 0, GAP, "R2_R6");
    runReq(1, 1, 19'h00005, 32'h0000_00EE, 4'b0001, FL_WR, FL_WP, GAP, "R6_R4_R5");
    runReq(0, 0, 19'h00000, 32'h0, 4'h0, SRAM_RD, 0, GAP, "R6_R4");
    testBusyIgnore();
    summary();
    $finish;
  end

endmodule